// File: doc/BRIEF.md
# Nibble-addressed bank register file

This block holds the bank selection state for one banking mode of a cartridge memory controller. An upstream router hands it a write strobe, a 16-bit CPU address and a byte of data. The block keeps two switchable 8 KB program bank registers, one nametable arrangement register and eight 1 KB pattern bank registers. It presents the resulting bank numbers continuously to the address-forming logic downstream.

Each pattern register is 8 bits wide but is filled four bits at a time. An even address writes the lower four bits and an odd address writes the upper four. The two upper program windows always point at the last two banks of program ROM. An external outer-bank input sets bit 8 of every pattern bank number. Every bank number is folded modulo the number of banks actually fitted before it leaves the block.

Top module: `nib_bank_regs`

## Requirements
- R1: A write whose address lies in 0x8000..0x8FFF loads program register 0, which drives program window 0. A write in 0xA000..0xAFFF loads program register 1, which drives window 1. All 8 data bits are stored.
- R2: Program windows 2 and 3 always output PRG_BANKS-2 and PRG_BANKS-1.
- R3: A write in 0x9000..0x9FFF loads the arrangement register. Output mirror_h equals its bit 0 (1 = horizontal, 0 = vertical).
- R4: A write in 0xB000..0xE003 selects pattern register index ((((A & 2) | (A >> 10)) >> 1) + 2) & 7. In particular 0xB000→0, 0xB002→1, 0xC000→2, 0xC002→3, 0xD000→4, 0xD002→5, 0xE000→6, 0xE002→7, and A+1 selects the same index as an even A.
- R5: For a pattern register write, an even address replaces bits [3:0] with data[3:0]. An odd address replaces bits [7:4] with data[3:0]. The other nibble is kept, and data[7:4] has no effect.
- R6: After reset the pattern registers hold 0xFF, 0xFF, 0xFF, 0xFF, 4, 5, 6, 7 (index 0 to 7), the program registers hold 0 and 1, and the arrangement register holds 0.
- R7: Pattern window i outputs ((outer_chr ? 256 : 0) | register i) modulo CHR_BANKS.
- R8: Program windows 0 and 1 output their register value modulo PRG_BANKS.
- R9: Nothing changes on writes with wr_en low, on addresses below 0x8000, and on addresses 0xE004..0xFFFF.
- R10: A write accepted at a rising clock edge shows on the outputs right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe from the router |
| wr_addr | input | 16 | CPU address of the write |
| wr_data | input | 8 | Write data |
| outer_chr | input | 1 | Outer pattern bank bit (adds 256) |
| prg_bank_o | output | 4*PRG_W | Program window bank numbers, window 0 in the low bits |
| chr_bank_o | output | 8*CHR_W | Pattern window bank numbers, window 0 in the low bits |
| mirror_h | output | 1 | 1 = horizontal arrangement, 0 = vertical |

## Verification
Every stored bit reaches a port combinationally, so a wrong register value shows on the matching window one clock after the write that caused it. A misrouted pattern index shows as a wrong window changing, or the right window not changing. A nibble mix-up shows as the wrong half of a bank number moving. A missed ignore shows as any window drifting after a write to an undecoded address. The bench mirrors the state from the requirements and compares all thirteen outputs after every scenario. It therefore catches a disturbed register even on a window that the scenario did not aim at.

// File: rtl/nib_bank_regs.sv
module nib_bank_regs #(
  parameter int PRG_BANKS = 20,
  parameter int CHR_BANKS = 384
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [15:0]                            wr_addr,
  input  logic [7:0]                             wr_data,
  input  logic                                   outer_chr,
  output logic [4*$clog2(PRG_BANKS)-1:0]         prg_bank_o,
  output logic [8*$clog2(CHR_BANKS)-1:0]         chr_bank_o,
  output logic                                   mirror_h
);
  localparam int PRG_W = $clog2(PRG_BANKS);
  localparam int CHR_W = $clog2(CHR_BANKS);

  logic [7:0]      prg0_q, prg1_q, mir_q;
  logic [7:0][7:0] chr_q;

  logic [3:0]  page;
  logic        hit, wr_prg0, wr_prg1, wr_mir, wr_chr;
  logic [15:0] mix;
  logic [2:0]  idx;

  assign page    = wr_addr[15:12];
  assign hit     = wr_en & wr_addr[15];
  assign wr_prg0 = hit && page == 4'h8;
  assign wr_mir  = hit && page == 4'h9;
  assign wr_prg1 = hit && page == 4'hA;
  assign wr_chr  = hit && wr_addr >= 16'hB000 && wr_addr <= 16'hE003;
  assign mix     = (wr_addr >> 10) | (wr_addr & 16'h0002);
  assign idx     = 3'((mix >> 1) + 16'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg0_q <= 8'd0;
      prg1_q <= 8'd1;
      mir_q  <= 8'd0;
      chr_q  <= {8'd7, 8'd6, 8'd5, 8'd4, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    end else begin
      if (wr_prg0) prg0_q <= wr_data;
      if (wr_prg1) prg1_q <= wr_data;
      if (wr_mir)  mir_q  <= wr_data;
      if (wr_chr) begin
        if (wr_addr[0]) chr_q[idx][7:4] <= wr_data[3:0];
        else            chr_q[idx][3:0] <= wr_data[3:0];
      end
    end
  end

  assign prg_bank_o[0*PRG_W +: PRG_W] = PRG_W'(32'(prg0_q) % PRG_BANKS);
  assign prg_bank_o[1*PRG_W +: PRG_W] = PRG_W'(32'(prg1_q) % PRG_BANKS);
  assign prg_bank_o[2*PRG_W +: PRG_W] = PRG_W'(PRG_BANKS - 2);
  assign prg_bank_o[3*PRG_W +: PRG_W] = PRG_W'(PRG_BANKS - 1);

  for (genvar i = 0; i < 8; i++) begin : g_chr
    assign chr_bank_o[i*CHR_W +: CHR_W] = CHR_W'(32'({outer_chr, chr_q[i]}) % CHR_BANKS);
  end

  assign mirror_h = mir_q[0];

  assert_prg0_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:12] == 4'h8) |=> prg0_q == $past(wr_data));
  assert_prg1_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:12] == 4'hA) |=> prg1_q == $past(wr_data));
  assert_mirror_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:12] == 4'h9) |=> mirror_h == $past(wr_data[0]));
  assert_low_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_chr && !wr_addr[0]) |=> chr_q[$past(idx)] == {$past(chr_q[idx][7:4]), $past(wr_data[3:0])});
  assert_high_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_chr && wr_addr[0]) |=> chr_q[$past(idx)] == {$past(wr_data[3:0]), $past(chr_q[idx][3:0])});
  assert_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr < 16'h8000 || wr_addr > 16'hE003)
      |=> ($stable(prg0_q) && $stable(prg1_q) && $stable(mir_q) && $stable(chr_q)));
endmodule

// File: tb/sim_nib_bank_regs.sv
module sim_nib_bank_regs;
  localparam int PB = 20;
  localparam int CB = 384;
  localparam int PW = $clog2(PB);
  localparam int CW = $clog2(CB);

  logic        clk = 0, rst_n = 0, wr_en = 0, outer = 0;
  logic [15:0] addr = 0;
  logic [7:0]  data = 0;
  wire [4*PW-1:0] prg;
  wire [8*CW-1:0] chr;
  wire            mir;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_prg [2];
  logic [7:0] m_chr [8];
  logic [7:0] m_mir;

  nib_bank_regs #(.PRG_BANKS(PB), .CHR_BANKS(CB)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr), .wr_data(data),
    .outer_chr(outer), .prg_bank_o(prg), .chr_bank_o(chr), .mirror_h(mir));

  always #5 clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_prg[0] = 0; m_prg[1] = 1; m_mir = 0;
    for (int i = 0; i < 4; i++) m_chr[i] = 8'hFF;
    for (int i = 4; i < 8; i++) m_chr[i] = 8'(i);
  endtask

  task automatic model_wr(logic [15:0] a, logic [7:0] d);
    int k;
    if (a >= 16'h8000 && a <= 16'h8FFF) m_prg[0] = d;
    else if (a >= 16'h9000 && a <= 16'h9FFF) m_mir = d;
    else if (a >= 16'hA000 && a <= 16'hAFFF) m_prg[1] = d;
    else if (a >= 16'hB000 && a <= 16'hE003) begin
      k = ((((int'(a) & 2) | (int'(a) >> 10)) >> 1) + 2) & 7;
      if (a[0]) m_chr[k][7:4] = d[3:0];
      else      m_chr[k][3:0] = d[3:0];
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 4; i++) begin
      int e;
      e = (i < 2) ? int'(m_prg[i]) % PB : PB - 4 + i;
      chk($sformatf("%s prg window %0d", tag, i), int'(prg[i*PW +: PW]), e);
    end
    for (int i = 0; i < 8; i++)
      chk($sformatf("%s chr window %0d", tag, i), int'(chr[i*CW +: CW]),
          ((outer ? 256 : 0) | int'(m_chr[i])) % CB);
    chk({tag, " mirror"}, int'(mir), int'(m_mir[0]));
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    model_wr(a, d);
  endtask

  task automatic t_reset();
    check_all("R6 R2 reset");
    chk("R6 chr0 raw", int'(chr[0 +: CW]), 255);
    chk("R2 window 2 fixed", int'(prg[2*PW +: PW]), PB - 2);
    chk("R2 window 3 fixed", int'(prg[3*PW +: PW]), PB - 1);
  endtask

  task automatic t_prg();
    wr(16'h8000, 8'd3);
    chk("R1 prg0", int'(prg[0 +: PW]), 3);
    wr(16'hA000, 8'd5);
    chk("R1 prg1", int'(prg[PW +: PW]), 5);
    wr(16'h8FFF, 8'h25);
    chk("R8 prg0 modulo", int'(prg[0 +: PW]), 17);
    wr(16'hAFFF, 8'd19);
    check_all("R1 R8 prg");
  endtask

  task automatic t_timing();
    @(negedge clk);
    addr = 16'h8123; data = 8'd7; wr_en = 1;
    #1 chk("R10 before edge", int'(prg[0 +: PW]), int'(m_prg[0]) % PB);
    @(negedge clk);
    wr_en = 0;
    model_wr(16'h8123, 8'd7);
    chk("R10 after edge", int'(prg[0 +: PW]), 7);
  endtask

  task automatic t_mirror();
    wr(16'h9000, 8'd1);
    chk("R3 horizontal", int'(mir), 1);
    wr(16'h9ABC, 8'hFE);
    chk("R3 vertical", int'(mir), 0);
    check_all("R3 mirror");
  endtask

  task automatic t_chr();
    logic [15:0] base [8];
    base = '{16'hB000, 16'hB002, 16'hC000, 16'hC002, 16'hD000, 16'hD002, 16'hE000, 16'hE002};
    wr(16'hB000, 8'h0A);
    wr(16'hB001, 8'h03);
    chk("R5 example 0x3A", int'(chr[0 +: CW]), 8'h3A);
    for (int i = 0; i < 8; i++) begin
      wr(base[i], 8'hF0 | 8'(i + 1));
      wr(base[i] + 16'd1, 8'hA0 | 8'(7 - i));
      chk($sformatf("R4 R5 index %0d", i), int'(chr[i*CW +: CW]), ((7 - i) << 4) | (i + 1));
    end
    wr(16'hC001, 8'h0C);
    chk("R5 low nibble kept", int'(chr[2*CW +: CW]), 8'hC3);
    check_all("R4 R5 chr");
  endtask

  task automatic t_outer();
    wr(16'hB000, 8'h0F);
    wr(16'hB001, 8'h0F);
    outer = 1;
    #1 chk("R7 outer modulo", int'(chr[0 +: CW]), 511 % CB);
    check_all("R7 outer on");
    outer = 0;
    #1 check_all("R7 outer off");
  endtask

  task automatic t_ignore();
    wr(16'h7000, 8'h11);
    wr(16'h0000, 8'h22);
    wr(16'hE004, 8'h0E);
    wr(16'hEFFF, 8'h0D);
    wr(16'hF000, 8'h33);
    wr(16'hFFFF, 8'h0B);
    check_all("R9 ignored addresses");
    @(negedge clk);
    addr = 16'h8000; data = 8'd9; wr_en = 0;
    @(negedge clk);
    addr = 16'hB001; data = 8'h05;
    @(negedge clk);
    check_all("R9 strobe low");
  endtask

  task automatic t_rereset();
    @(negedge clk);
    rst_n = 0;
    #1 model_reset();
    check_all("R6 async reset");
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_prg();
    t_timing();
    t_mirror();
    t_chr();
    t_outer();
    t_ignore();
    t_rereset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule